// File: doc/BRIEF.md
# Soft-Start and Fault Supervisor Sequencer

This block sequences the start-up of a switching regulator and watches its fault flags. It counts ticks of the switching clock and keeps three separate timers. The first timer ramps a current-limit code so that inrush current stays bounded. The second arms output-undervoltage protection once the output has had time to settle. The third holds an active-low reset output through a long power-on interval. The analog comparators, the current-limit DAC and the gate drivers sit outside the block. The block sees them only as one-bit flags and as its own output commands.

Fault flags are latched into two shutdown kinds. A crowbar fault comes from output overvoltage or from lockout of either supply input. It stops switching and forces the synchronous low-side switch on. A halt fault comes from over-temperature or from armed output undervoltage. It tri-states the power stage. Both kinds stay latched until the run-enable input is taken low. That shutdown also clears every timer, so the next enable starts a fresh ramp from zero.

Top module: `ss_supervisor`

## Requirements
- R1: `ilimCode` equals the number of counted ticks since enable divided by 128, capped at 4. It therefore steps 0, 1, 2, 3, 4, reaches 4 after 512 ticks and holds there.
- R2: `resetN` stays 0 until 32768 ticks have been counted. It rises at the clock edge after the edge that counts the 32768th tick, provided no other condition holds it low.
- R3: While `smpsLow` or `ldoLow` is high at a clock edge, `resetN` is 0 after that edge. It may rise again at the first edge at which both flags are low.
- R4: `smpsLow` causes no fault before 5000 ticks have been counted. From then on, `smpsLow` high at an edge latches a halt fault.
- R5: `ovFlag`, `vinLow` or `biasLow` high at an edge while running latches a crowbar fault. After that edge `forceLowSide`=1, `regEnable`=0 and `tristateReq`=0, until shutdown.
- R6: `otFlag` high at an edge while running latches a halt fault. After that edge `tristateReq`=1 and `regEnable`=0.
- R7: A crowbar fault overrides a halt fault. When both are latched, `forceLowSide`=1 and `tristateReq`=0.
- R8: While `runEn`=0, the outputs are `tristateReq`=1, `resetN`=0, `regEnable`=0, `forceLowSide`=0 and `ilimCode`=0, with no clock delay. The first edge with `runEn`=0 clears both fault latches and all three timers.
- R9: While any fault is latched, the timers hold, `ilimCode`=0 and `resetN`=0.
- R10: A timer counts only at edges where `cycleTick`=1. Edges with `cycleTick`=0 leave `ilimCode` unchanged.
- R11: `rstN`=0 clears the timers, the latches and the reset register at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run enable; low means shutdown |
| cycleTick | input | 1 | One-cycle pulse per switching cycle |
| ovFlag | input | 1 | Output overvoltage comparator flag |
| vinLow | input | 1 | Battery input undervoltage lockout flag |
| biasLow | input | 1 | Bias supply undervoltage lockout flag |
| otFlag | input | 1 | Over-temperature flag (already filtered) |
| smpsLow | input | 1 | Switching output more than 10% low |
| ldoLow | input | 1 | Linear output more than 10% low |
| ilimCode | output | CODE_W (3) | Current-limit setpoint code 0..4 |
| resetN | output | 1 | Active-low system reset |
| regEnable | output | 1 | Regulator may switch |
| forceLowSide | output | 1 | Hold low-side switch on |
| tristateReq | output | 1 | Float both gate drivers |

## Verification
Four properties are checked on every cycle:
- Crowbar and tri-state never show together.
- A latched crowbar holds for as long as the block runs.
- An over-temperature flag or a low-output flag pulls `regEnable` or `resetN` down one edge later.
- The ramp code only steps up by one or returns to zero, and the reset timer can finish only after undervoltage is armed.

The exact tick counts can be shown only by the bench's scenarios: the code change at tick 128, release at 32768 counted ticks, and undervoltage ignored before 5000 ticks but latched after. So can the clearing effect of a shutdown and the behaviour under sparse random ticks.

// File: rtl/ss_supervisor_pkg.sv
package ss_supervisor_pkg;
  // Strobes from the fault control to the timer datapath.
  typedef struct packed {
    logic clear;    // zero all timers
    logic countEn;  // timers may advance on a tick
  } timerCtl_t;
endpackage

// File: rtl/ss_seq_timer.sv
module ss_seq_timer #(
  parameter int LIMIT = 16,
  parameter int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         advance,
  output logic [W-1:0] count,
  output logic         done
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  assign done = (count == LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 count <= '0;
    else if (clear)            count <= '0;
    else if (advance && !done) count <= count + 1'b1;
  end

  // R9 / R10: without an advance or clear the count never moves
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !clear) |=> $stable(count));

  // R1: a finished timer saturates until cleared
  assert_saturate_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && !clear) |=> done);
endmodule

// File: rtl/ss_datapath.sv
module ss_datapath
  import ss_supervisor_pkg::*;
#(
  parameter int STEP_TICKS    = 128,
  parameter int RAMP_STEPS    = 4,
  parameter int ARM_TICKS     = 5000,
  parameter int RELEASE_TICKS = 32768,
  parameter int CODE_W        = $clog2(RAMP_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  timerCtl_t         ctl,
  input  logic              cycleTick,
  output logic [CODE_W-1:0] rampCode,
  output logic              uvArmed,
  output logic              releaseDone
);
  localparam int RAMP_TICKS = STEP_TICKS * RAMP_STEPS;
  localparam int MAX_A      = (RAMP_TICKS > ARM_TICKS) ? RAMP_TICKS : ARM_TICKS;
  localparam int MAX_TICKS  = (MAX_A > RELEASE_TICKS) ? MAX_A : RELEASE_TICKS;
  localparam int TW         = $clog2(MAX_TICKS + 1);
  localparam int NTMR       = 3;
  localparam int LIMITS [NTMR] = '{RAMP_TICKS, ARM_TICKS, RELEASE_TICKS};

  logic [TW-1:0] cnt  [NTMR];
  logic          done [NTMR];
  logic          advance;

  assign advance = ctl.countEn && cycleTick;

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    ss_seq_timer #(.LIMIT(LIMITS[i]), .W(TW)) u_tmr (
      .clk     (clk),
      .rstN    (rstN),
      .clear   (ctl.clear),
      .advance (advance),
      .count   (cnt[i]),
      .done    (done[i])
    );
  end

  logic [TW-1:0] stepIdx;
  assign stepIdx     = cnt[0] / TW'(STEP_TICKS);
  assign rampCode    = CODE_W'(stepIdx);
  assign uvArmed     = done[1];
  assign releaseDone = done[2];

  logic unusedTimerBits;
  assign unusedTimerBits = ^{cnt[1], cnt[2], done[0]};

  // R1: the code climbs one step at a time or restarts at zero
  assert_ramp_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rampCode) |-> ((rampCode == $past(rampCode) + 1'b1) || (rampCode == '0)));

  assert_ramp_max_R1: assert property (@(posedge clk) disable iff (!rstN)
    rampCode <= CODE_W'(RAMP_STEPS));

  // R2: reset release cannot finish before undervoltage is armed
  assert_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(releaseDone) |-> uvArmed);
endmodule

// File: rtl/ss_control.sv
module ss_control
  import ss_supervisor_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              ovFlag,
  input  logic              vinLow,
  input  logic              biasLow,
  input  logic              otFlag,
  input  logic              smpsLow,
  input  logic              ldoLow,
  input  logic              uvArmed,
  input  logic              releaseDone,
  input  logic [CODE_W-1:0] rampCode,
  output timerCtl_t         ctl,
  output logic [CODE_W-1:0] ilimCode,
  output logic              resetN,
  output logic              regEnable,
  output logic              forceLowSide,
  output logic              tristateReq
);
  logic crowbarQ, haltQ, relQ;
  logic crowbarNext, haltNext, faulted;

  assign crowbarNext = crowbarQ || ovFlag || vinLow || biasLow;
  assign haltNext    = haltQ || otFlag || (smpsLow && uvArmed);
  assign faulted     = crowbarQ || haltQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crowbarQ <= 1'b0;
      haltQ    <= 1'b0;
      relQ     <= 1'b0;
    end else if (!runEn) begin
      crowbarQ <= 1'b0;
      haltQ    <= 1'b0;
      relQ     <= 1'b0;
    end else begin
      crowbarQ <= crowbarNext;
      haltQ    <= haltNext;
      relQ     <= releaseDone && !smpsLow && !ldoLow && !crowbarNext && !haltNext;
    end
  end

  always_comb begin
    ctl.clear    = !runEn;
    ctl.countEn  = runEn && !faulted;
    regEnable    = runEn && !faulted;
    forceLowSide = runEn && crowbarQ;
    tristateReq  = !runEn || (haltQ && !crowbarQ);
    resetN       = runEn && relQ;
    ilimCode     = regEnable ? rampCode : '0;
  end

  // R7: crowbar and floating drivers are mutually exclusive
  assert_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    forceLowSide |-> (!tristateReq && !regEnable));

  // R5: a crowbar stays latched while the block keeps running
  assert_latch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && crowbarQ) |=> (forceLowSide || !runEn));

  // R3: a low output flag holds reset on the following cycle
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (smpsLow || ldoLow) |=> !resetN);

  // R6: over-temperature stops switching on the next edge
  assert_trip_R6: assert property (@(posedge clk) disable iff (!rstN)
    otFlag |=> !regEnable);
endmodule

// File: rtl/ss_supervisor.sv
module ss_supervisor
  import ss_supervisor_pkg::*;
#(
  parameter int STEP_TICKS    = 128,
  parameter int RAMP_STEPS    = 4,
  parameter int ARM_TICKS     = 5000,
  parameter int RELEASE_TICKS = 32768,
  parameter int CODE_W        = $clog2(RAMP_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              cycleTick,
  input  logic              ovFlag,
  input  logic              vinLow,
  input  logic              biasLow,
  input  logic              otFlag,
  input  logic              smpsLow,
  input  logic              ldoLow,
  output logic [CODE_W-1:0] ilimCode,
  output logic              resetN,
  output logic              regEnable,
  output logic              forceLowSide,
  output logic              tristateReq
);
  timerCtl_t         ctl;
  logic [CODE_W-1:0] rampCode;
  logic              uvArmed, releaseDone;

  ss_datapath #(
    .STEP_TICKS(STEP_TICKS), .RAMP_STEPS(RAMP_STEPS), .ARM_TICKS(ARM_TICKS),
    .RELEASE_TICKS(RELEASE_TICKS), .CODE_W(CODE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cycleTick(cycleTick),
    .rampCode(rampCode), .uvArmed(uvArmed), .releaseDone(releaseDone)
  );

  ss_control #(.CODE_W(CODE_W)) u_ctl (
    .clk(clk), .rstN(rstN), .runEn(runEn),
    .ovFlag(ovFlag), .vinLow(vinLow), .biasLow(biasLow), .otFlag(otFlag),
    .smpsLow(smpsLow), .ldoLow(ldoLow),
    .uvArmed(uvArmed), .releaseDone(releaseDone), .rampCode(rampCode),
    .ctl(ctl), .ilimCode(ilimCode), .resetN(resetN), .regEnable(regEnable),
    .forceLowSide(forceLowSide), .tristateReq(tristateReq)
  );
endmodule

// File: tb/ss_supervisor_test.sv
module ss_supervisor_test;
  localparam int STEP = 128, STEPS = 4, ARM = 5000, REL = 32768;

  logic clk = 1'b0, rstN = 1'b0, runEn = 1'b0, cycleTick = 1'b0;
  logic ovFlag = 1'b0, vinLow = 1'b0, biasLow = 1'b0, otFlag = 1'b0;
  logic smpsLow = 1'b0, ldoLow = 1'b0;
  logic [2:0] ilimCode;
  logic resetN, regEnable, forceLowSide, tristateReq;

  int vectors = 0, miscompares = 0;
  int mRamp = 0, mArm = 0, mRel = 0;
  bit mCrow = 0, mHalt = 0, mRelQ = 0;

  ss_supervisor uut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cycleTick(cycleTick),
    .ovFlag(ovFlag), .vinLow(vinLow), .biasLow(biasLow), .otFlag(otFlag),
    .smpsLow(smpsLow), .ldoLow(ldoLow), .ilimCode(ilimCode), .resetN(resetN),
    .regEnable(regEnable), .forceLowSide(forceLowSide), .tristateReq(tristateReq)
  );

  always #5 clk = ~clk;

  // Reference model built from the requirements
  always @(posedge clk or negedge rstN) begin : model
    bit cN, hN;
    if (!rstN || !runEn) begin
      mRamp = 0; mArm = 0; mRel = 0; mCrow = 0; mHalt = 0; mRelQ = 0;
    end else begin
      cN = mCrow || ovFlag || vinLow || biasLow;
      hN = mHalt || otFlag || (smpsLow && mArm >= ARM);
      mRelQ = (mRel >= REL) && !smpsLow && !ldoLow && !cN && !hN;
      if (cycleTick && !mCrow && !mHalt) begin
        if (mRamp < STEP * STEPS) mRamp++;
        if (mArm < ARM) mArm++;
        if (mRel < REL) mRel++;
      end
      mCrow = cN; mHalt = hN;
    end
  end

  function automatic int expCode();
    int q;
    if (!(runEn && !mCrow && !mHalt)) return 0;
    q = mRamp / STEP;
    return (q > STEPS) ? STEPS : q;
  endfunction

  task automatic expectVal(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    vectors++;
    if (int'(ilimCode) != expCode()) begin
      miscompares++;
      $display("FAIL R1 ilimCode: actual %0d expected %0d at %0t", ilimCode, expCode(), $time);
    end
    if (resetN !== (runEn && mRelQ)) begin
      miscompares++;
      $display("FAIL R2 resetN: actual %0d expected %0d at %0t", resetN, runEn && mRelQ, $time);
    end
    if (regEnable !== (runEn && !mCrow && !mHalt)) begin
      miscompares++;
      $display("FAIL R9 regEnable: actual %0d expected %0d at %0t", regEnable,
               runEn && !mCrow && !mHalt, $time);
    end
    if (forceLowSide !== (runEn && mCrow)) begin
      miscompares++;
      $display("FAIL R5 forceLowSide: actual %0d expected %0d at %0t", forceLowSide,
               runEn && mCrow, $time);
    end
    if (tristateReq !== (!runEn || (mHalt && !mCrow))) begin
      miscompares++;
      $display("FAIL R6 tristateReq: actual %0d expected %0d at %0t", tristateReq,
               !runEn || (mHalt && !mCrow), $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    checkAll();
  endtask

  task automatic tickRun(int n);
    cycleTick = 1'b1;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic idle(int n);
    cycleTick = 1'b0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic shutdownRestart();
    runEn = 1'b0;
    #1 checkAll();
    expectVal("R8", "tristateReq in shutdown", tristateReq, 1);
    expectVal("R8", "resetN in shutdown", resetN, 0);
    expectVal("R8", "forceLowSide in shutdown", forceLowSide, 0);
    idle(3);
    runEn = 1'b1;
    step();
    expectVal("R8", "regEnable after restart", regEnable, 1);
    expectVal("R8", "ilimCode after restart", ilimCode, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    int seedInit;
    seedInit = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    checkAll();
    expectVal("R11", "tristateReq in reset", tristateReq, 1);
    expectVal("R11", "resetN in reset", resetN, 0);
    expectVal("R11", "ilimCode in reset", ilimCode, 0);
    rstN = 1'b1;

    // Full power-up with a tick every cycle
    runEn = 1'b1;
    tickRun(127); expectVal("R1", "code after 127 ticks", ilimCode, 0);
    tickRun(1);   expectVal("R1", "code after 128 ticks", ilimCode, 1);
    idle(300);    expectVal("R10", "code held without ticks", ilimCode, 1);
    tickRun(127); expectVal("R1", "code after 255 ticks", ilimCode, 1);
    tickRun(1);   expectVal("R1", "code after 256 ticks", ilimCode, 2);
    tickRun(256); expectVal("R1", "code after 512 ticks", ilimCode, 4);
    tickRun(488); expectVal("R1", "code held at 4", ilimCode, 4);
    smpsLow = 1'b1; tickRun(3); smpsLow = 1'b0; tickRun(1);
    expectVal("R4", "regEnable with early undervoltage", regEnable, 1);
    expectVal("R4", "tristateReq with early undervoltage", tristateReq, 0);
    tickRun(REL - 1004);
    expectVal("R2", "resetN at 32768 ticks", resetN, 0);
    tickRun(1);
    expectVal("R2", "resetN one edge later", resetN, 1);
    ldoLow = 1'b1; step(); expectVal("R3", "resetN with ldoLow", resetN, 0);
    ldoLow = 1'b0; step(); expectVal("R3", "resetN after ldoLow", resetN, 1);
    smpsLow = 1'b1; step(); smpsLow = 1'b0;
    expectVal("R4", "tristateReq after armed undervoltage", tristateReq, 1);
    expectVal("R4", "regEnable after armed undervoltage", regEnable, 0);
    tickRun(5);
    expectVal("R9", "resetN while halted", resetN, 0);
    ovFlag = 1'b1; step(); ovFlag = 1'b0;
    expectVal("R7", "forceLowSide over halt", forceLowSide, 1);
    expectVal("R7", "tristateReq over halt", tristateReq, 0);
    shutdownRestart();

    tickRun(200);
    vinLow = 1'b1; step(); vinLow = 1'b0;
    expectVal("R5", "forceLowSide after vinLow", forceLowSide, 1);
    tickRun(300);
    expectVal("R9", "ilimCode while crowbarred", ilimCode, 0);
    shutdownRestart();
    tickRun(20);
    biasLow = 1'b1; step(); biasLow = 1'b0;
    expectVal("R5", "regEnable after biasLow", regEnable, 0);
    shutdownRestart();
    tickRun(50);
    otFlag = 1'b1; step(); otFlag = 1'b0;
    expectVal("R6", "tristateReq after otFlag", tristateReq, 1);
    shutdownRestart();
    tickRun(300);
    @(negedge clk); rstN = 1'b0;
    #1 expectVal("R11", "ilimCode under async reset", ilimCode, 0);
    step(); rstN = 1'b1; step();

    // Random episodes with sparse ticks and rare flags
    for (int ep = 0; ep < 20; ep++) begin
      int len;
      runEn = 1'b0; idle(2); runEn = 1'b1;
      len = $urandom_range(3000, 300);
      for (int c = 0; c < len; c++) begin
        cycleTick = ($urandom_range(3, 0) != 0);
        ovFlag  = ($urandom_range(1999, 0) == 0);
        vinLow  = ($urandom_range(1999, 0) == 0);
        biasLow = ($urandom_range(1999, 0) == 0);
        otFlag  = ($urandom_range(1499, 0) == 0);
        smpsLow = ($urandom_range(299, 0) == 0);
        ldoLow  = ($urandom_range(299, 0) == 0);
        step();
      end
      {ovFlag, vinLow, biasLow, otFlag, smpsLow, ldoLow} = '0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule